// File: doc/BRIEF.md
# IDE Bus-Master DMA Channel Status Register

This block holds the status byte for each channel of an IDE bus-master DMA engine. The primary and secondary channels each get their own copy, and the copies share nothing. Software reads each byte through a byte-wide read/write port. It uses the same port to set two capability flags and to clear the interrupt and error flags by writing 1 to them.

Hardware events move the remaining bits. A drive interrupt line, once filtered, raises the interrupt flag. A failed memory transfer raises the error flag. The active flag follows three events: writes to the command start bit, aborts, and completion of the last transfer of an end-of-table descriptor. When data is moving from the device to memory, an interrupt edge that arrives while buffered data is still draining is held back. The flag is raised only after the drain completes.

Top module: `ide_bm_status`

## Requirements
- R1: After a synchronous reset every channel's status byte reads 00h.
- R2: Bits 7, 4 and 3 always read 0. A register write does not change these bits or bit 0.
- R3: Bit 6 (slave capable) and bit 5 (master capable) take the written value on each register write and hold it otherwise.
- R4: The drive interrupt line is filtered. It must stay high for 3 consecutive sampling edges before bit 2 can be set. Bit 2 reads 1 after the 4th edge and still reads 0 after the 3rd. A shorter high pulse never sets it.
- R5: Writing a 1 in bit 2 clears the interrupt flag. Writing a 0 in bit 2 leaves it unchanged.
- R6: While the direction flag is 1 (device to memory) and the drain-busy input is 1, bit 2 is not set. A filtered edge seen in that state is held pending. Bit 2 is then set on the first clock edge that samples drain-busy as 0.
- R7: When a hardware set of bit 2 or bit 1 falls in the same cycle as a write-1-to-clear of that bit, the bit ends up set.
- R8: A transfer-error pulse sets bit 1. Writing a 1 in bit 1 clears it.
- R9: A start write sets bit 0 to the carried start value. An end-of-table completion clears bit 0. When both happen in the same cycle, the start write decides.
- R10: The channels are independent. Inputs to one channel never change another channel's byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | NUM_CHAN | Per-channel register write strobe |
| reg_wdata | input | NUM_CHAN x 8 | Per-channel write data |
| reg_rdata | output | NUM_CHAN x 8 | Per-channel status byte |
| drv_irq | input | NUM_CHAN | Raw drive interrupt line |
| xfer_err | input | NUM_CHAN | Memory transfer error pulse |
| start_wr | input | NUM_CHAN | Command start-bit write strobe |
| start_val | input | NUM_CHAN | Value written to the start bit |
| eot_done | input | NUM_CHAN | Final transfer of end-of-table descriptor done |
| dir_to_mem | input | NUM_CHAN | 1 when data moves from device to memory |
| drain_busy | input | NUM_CHAN | 1 while buffered device data is still draining |

## Verification
Two pairs of events can collide in one cycle. A hardware set of the interrupt or error flag can coincide with a software write-1-to-clear. A start write can coincide with an end-of-table completion. The interrupt collision is provoked directly: with an edge held pending, drain-busy is dropped in the same cycle as a clear write of bit 2, and the bit must still read 1. The error and active collisions get the same treatment, and the expected winner is taken from R7 and R9. A random phase then drives both channels with all inputs at once and compares every cycle against a bench model.

// File: rtl/ide_bm_stat_pkg.sv
package ide_bm_stat_pkg;

    localparam int STAT_W  = 8;
    localparam int BIT_SLV = 6;
    localparam int BIT_MST = 5;
    localparam int BIT_IRQ = 2;
    localparam int BIT_ERR = 1;
    localparam int BIT_ACT = 0;

    typedef struct packed {
        logic slv_cap;
        logic mst_cap;
        logic irq;
        logic err;
        logic act;
    } stat_t;

    typedef struct packed {
        logic irq_set;
        logic err_set;
        logic start_wr;
        logic start_val;
        logic eot;
    } hw_evt_t;

    function automatic logic [STAT_W-1:0] stat_to_byte(input stat_t s);
        logic [STAT_W-1:0] b;
        b          = '0;
        b[BIT_SLV] = s.slv_cap;
        b[BIT_MST] = s.mst_cap;
        b[BIT_IRQ] = s.irq;
        b[BIT_ERR] = s.err;
        b[BIT_ACT] = s.act;
        return b;
    endfunction

    // sticky flag: hardware set has priority over a software clear
    function automatic logic w1c_next(input logic cur, input logic set,
                                      input logic wr, input logic wbit);
        return set | (cur & ~(wr & wbit));
    endfunction

endpackage

// File: rtl/irq_level_filter.sv
module irq_level_filter #(
    parameter int HOLD = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic level_o
);
    localparam int CW = (HOLD < 2) ? 1 : $clog2(HOLD + 1);

    logic          level_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
            run_q   <= '0;
        end else if (raw_i == level_q) begin
            run_q <= '0;
        end else if (run_q == CW'(HOLD - 1)) begin
            level_q <= raw_i;
            run_q   <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign level_o = level_q;

    // R4: the filtered level only moves to a value the input held at the previous edge
    a_r4_filter_follows_input: assert property (@(posedge clk) disable iff (rst)
        (level_q != $past(level_q)) |-> ($past(raw_i) == level_q));

endmodule

// File: rtl/irq_edge_defer.sv
module irq_edge_defer (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    input  logic dir_to_mem_i,
    input  logic drain_busy_i,
    output logic set_o
);
    logic level_d_q;
    logic pend_q;
    logic blocked;
    logic want;

    assign blocked = dir_to_mem_i & drain_busy_i;
    assign want    = (level_i & ~level_d_q) | pend_q;
    assign set_o   = want & ~blocked;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_d_q <= 1'b0;
            pend_q    <= 1'b0;
        end else begin
            level_d_q <= level_i;
            pend_q    <= want & blocked;
        end
    end

    // R6: a held edge is released as soon as draining stops
    a_r6_pending_released: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !drain_busy_i) |-> set_o);

endmodule

// File: rtl/bm_chan_status.sv
module bm_chan_status
    import ide_bm_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [STAT_W-1:0] wdata_i,
    input  hw_evt_t           evt_i,
    output logic [STAT_W-1:0] rdata_o
);
    stat_t stat_q;
    stat_t stat_d;

    wire unused_wbits = ^{wdata_i[7], wdata_i[4:3], wdata_i[BIT_ACT]};

    always_comb begin
        stat_d         = stat_q;
        stat_d.slv_cap = wr_i ? wdata_i[BIT_SLV] : stat_q.slv_cap;
        stat_d.mst_cap = wr_i ? wdata_i[BIT_MST] : stat_q.mst_cap;
        stat_d.irq     = w1c_next(stat_q.irq, evt_i.irq_set, wr_i, wdata_i[BIT_IRQ]);
        stat_d.err     = w1c_next(stat_q.err, evt_i.err_set, wr_i, wdata_i[BIT_ERR]);
        if (evt_i.start_wr)
            stat_d.act = evt_i.start_val;
        else if (evt_i.eot)
            stat_d.act = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_d;
    end

    assign rdata_o = stat_to_byte(stat_q);

    // R1: byte is zero right after reset
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rdata_o == '0));
    // R3: capability flags take the written value
    a_r3_caps_written: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> (rdata_o[BIT_SLV:BIT_MST] == $past(wdata_i[BIT_SLV:BIT_MST])));
    // R5: write-1 clears the interrupt flag when no set competes
    a_r5_irq_w1c: assert property (@(posedge clk) disable iff (rst)
        (wr_i && wdata_i[BIT_IRQ] && !evt_i.irq_set) |=> !rdata_o[BIT_IRQ]);
    // R7: set beats clear
    a_r7_irq_set_wins: assert property (@(posedge clk) disable iff (rst)
        evt_i.irq_set |=> rdata_o[BIT_IRQ]);
    // R8: error pulse sets bit 1
    a_r8_err_set: assert property (@(posedge clk) disable iff (rst)
        evt_i.err_set |=> rdata_o[BIT_ERR]);
    // R9: start write determines the active bit
    a_r9_start_value: assert property (@(posedge clk) disable iff (rst)
        evt_i.start_wr |=> (rdata_o[BIT_ACT] == $past(evt_i.start_val)));
    // R9: end-of-table clears active without a start write
    a_r9_eot_clears: assert property (@(posedge clk) disable iff (rst)
        (evt_i.eot && !evt_i.start_wr) |=> !rdata_o[BIT_ACT]);

endmodule

// File: rtl/ide_bm_status.sv
module ide_bm_status
    import ide_bm_stat_pkg::*;
#(
    parameter int NUM_CHAN  = 2,
    parameter int FILT_HOLD = 3
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_CHAN-1:0]              reg_wr,
    input  logic [NUM_CHAN-1:0][STAT_W-1:0]  reg_wdata,
    output logic [NUM_CHAN-1:0][STAT_W-1:0]  reg_rdata,
    input  logic [NUM_CHAN-1:0]              drv_irq,
    input  logic [NUM_CHAN-1:0]              xfer_err,
    input  logic [NUM_CHAN-1:0]              start_wr,
    input  logic [NUM_CHAN-1:0]              start_val,
    input  logic [NUM_CHAN-1:0]              eot_done,
    input  logic [NUM_CHAN-1:0]              dir_to_mem,
    input  logic [NUM_CHAN-1:0]              drain_busy
);
    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        logic    irq_level;
        logic    irq_set;
        hw_evt_t evt;

        irq_level_filter #(.HOLD(FILT_HOLD)) u_filt (
            .clk     (clk),
            .rst     (rst),
            .raw_i   (drv_irq[c]),
            .level_o (irq_level)
        );

        irq_edge_defer u_defer (
            .clk          (clk),
            .rst          (rst),
            .level_i      (irq_level),
            .dir_to_mem_i (dir_to_mem[c]),
            .drain_busy_i (drain_busy[c]),
            .set_o        (irq_set)
        );

        assign evt = '{irq_set:   irq_set,
                       err_set:   xfer_err[c],
                       start_wr:  start_wr[c],
                       start_val: start_val[c],
                       eot:       eot_done[c]};

        bm_chan_status u_stat (
            .clk     (clk),
            .rst     (rst),
            .wr_i    (reg_wr[c]),
            .wdata_i (reg_wdata[c]),
            .evt_i   (evt),
            .rdata_o (reg_rdata[c])
        );

        // R6: interrupt flag never rises from an edge taken while draining
        a_r6_no_rise_while_draining: assert property (@(posedge clk) disable iff (rst)
            $rose(reg_rdata[c][BIT_IRQ]) |-> !$past(dir_to_mem[c] && drain_busy[c]));
    end

endmodule

// File: tb/ide_bm_status_test.sv
module ide_bm_status_test;
    localparam int CLK_P = 10;
    localparam int NC    = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NC-1:0]       reg_wr = '0, drv_irq = '0, xfer_err = '0, start_wr = '0;
    logic [NC-1:0]       start_val = '0, eot_done = '0, dir_to_mem = '0, drain_busy = '0;
    logic [NC-1:0][7:0]  reg_wdata = '0;
    logic [NC-1:0][7:0]  reg_rdata;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_P/2) clk = ~clk;

    ide_bm_status #(.NUM_CHAN(NC), .FILT_HOLD(3)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .drv_irq(drv_irq), .xfer_err(xfer_err),
        .start_wr(start_wr), .start_val(start_val), .eot_done(eot_done),
        .dir_to_mem(dir_to_mem), .drain_busy(drain_busy)
    );

    // bench model built from R1..R10
    logic       m_lvl[NC], m_lvl_d[NC], m_pend[NC];
    int         m_run[NC];
    logic [7:0] m_reg[NC];

    function automatic logic [7:0] ref_next(input logic [7:0] cur, input logic iset,
        input logic eset, input logic wr, input logic [7:0] wd,
        input logic sw, input logic sv, input logic eot);
        logic [7:0] n;
        n    = cur & 8'h67;
        if (wr) n[6:5] = wd[6:5];
        n[2] = iset | (cur[2] & ~(wr & wd[2]));
        n[1] = eset | (cur[1] & ~(wr & wd[1]));
        n[0] = sw ? sv : (eot ? 1'b0 : cur[0]);
        return n;
    endfunction

    always @(posedge clk) begin
        for (int c = 0; c < NC; c++) begin
            if (rst) begin
                m_lvl[c] = 0; m_lvl_d[c] = 0; m_pend[c] = 0; m_run[c] = 0; m_reg[c] = 0;
            end else begin
                logic blk, want, iset;
                blk  = dir_to_mem[c] & drain_busy[c];
                want = (m_lvl[c] & ~m_lvl_d[c]) | m_pend[c];
                iset = want & ~blk;
                m_pend[c]  = want & blk;
                m_lvl_d[c] = m_lvl[c];
                if (drv_irq[c] == m_lvl[c]) m_run[c] = 0;
                else if (m_run[c] == 2) begin m_lvl[c] = drv_irq[c]; m_run[c] = 0; end
                else m_run[c] = m_run[c] + 1;
                m_reg[c] = ref_next(m_reg[c], iset, xfer_err[c], reg_wr[c], reg_wdata[c],
                                    start_wr[c], start_val[c], eot_done[c]);
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr0(input logic [7:0] d);
        reg_wr[0] = 1'b1; reg_wdata[0] = d; tick(1); reg_wr[0] = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1DE5));
        tick(3);
        rst = 1'b0;
        tick(1);
        chk("R1 ch0 reset", reg_rdata[0], 8'h00);
        chk("R1 ch1 reset", reg_rdata[1], 8'h00);

        wr0(8'hFF);
        chk("R2 reserved bits and bit0 ignore write", reg_rdata[0], 8'h60);
        wr0(8'h20);
        chk("R3 caps follow write", reg_rdata[0], 8'h20);
        wr0(8'h00);
        chk("R3 caps cleared", reg_rdata[0], 8'h00);

        drv_irq[0] = 1'b1; tick(2); drv_irq[0] = 1'b0; tick(5);
        chk("R4 short pulse ignored", reg_rdata[0], 8'h00);
        drv_irq[0] = 1'b1; tick(3);
        chk("R4 not set after 3 edges", reg_rdata[0], 8'h00);
        tick(1);
        chk("R4 set after 4th edge", reg_rdata[0], 8'h04);

        wr0(8'h00);
        chk("R5 write 0 keeps irq", reg_rdata[0], 8'h04);
        wr0(8'h04);
        chk("R5 write 1 clears irq", reg_rdata[0], 8'h00);

        drv_irq[0] = 1'b0; tick(4);
        dir_to_mem[0] = 1'b1; drain_busy[0] = 1'b1; drv_irq[0] = 1'b1; tick(8);
        chk("R6 held while draining", reg_rdata[0], 8'h00);
        drain_busy[0] = 1'b0; tick(1);
        chk("R6 set after drain", reg_rdata[0], 8'h04);

        drv_irq[0] = 1'b0; tick(4);
        drain_busy[0] = 1'b1; drv_irq[0] = 1'b1; tick(6);
        drain_busy[0] = 1'b0; reg_wr[0] = 1'b1; reg_wdata[0] = 8'h04; tick(1);
        reg_wr[0] = 1'b0;
        chk("R7 irq set beats clear", reg_rdata[0], 8'h04);
        wr0(8'h04);
        chk("R5 clear after collision", reg_rdata[0], 8'h00);
        dir_to_mem[0] = 1'b0; drv_irq[0] = 1'b0; tick(4);

        xfer_err[0] = 1'b1; tick(1); xfer_err[0] = 1'b0;
        chk("R8 error set", reg_rdata[0], 8'h02);
        xfer_err[0] = 1'b1; reg_wr[0] = 1'b1; reg_wdata[0] = 8'h02; tick(1);
        xfer_err[0] = 1'b0; reg_wr[0] = 1'b0;
        chk("R7 error set beats clear", reg_rdata[0], 8'h02);
        wr0(8'h02);
        chk("R8 error cleared", reg_rdata[0], 8'h00);

        start_wr[0] = 1'b1; start_val[0] = 1'b1; tick(1); start_wr[0] = 1'b0;
        chk("R9 start sets active", reg_rdata[0], 8'h01);
        eot_done[0] = 1'b1; tick(1); eot_done[0] = 1'b0;
        chk("R9 end-of-table clears", reg_rdata[0], 8'h00);
        start_wr[0] = 1'b1; start_val[0] = 1'b1; tick(1);
        start_val[0] = 1'b0; tick(1); start_wr[0] = 1'b0;
        chk("R9 abort clears", reg_rdata[0], 8'h00);
        start_wr[0] = 1'b1; start_val[0] = 1'b1; eot_done[0] = 1'b1; tick(1);
        start_wr[0] = 1'b0; eot_done[0] = 1'b0;
        chk("R9 start beats end-of-table", reg_rdata[0], 8'h01);
        chk("R10 ch1 untouched", reg_rdata[1], 8'h00);

        for (int k = 0; k < 3000; k++) begin
            for (int c = 0; c < NC; c++) begin
                if ($urandom_range(5) == 0) drv_irq[c] = ~drv_irq[c];
                reg_wr[c]     = ($urandom_range(7) == 0);
                reg_wdata[c]  = 8'($urandom);
                xfer_err[c]   = ($urandom_range(15) == 0);
                start_wr[c]   = ($urandom_range(9) == 0);
                start_val[c]  = 1'($urandom);
                eot_done[c]   = ($urandom_range(9) == 0);
                if ($urandom_range(20) == 0) dir_to_mem[c] = ~dir_to_mem[c];
                if ($urandom_range(4) == 0)  drain_busy[c] = ~drain_busy[c];
            end
            tick(1);
            chk("R10 ch0 vs model", reg_rdata[0], m_reg[0]);
            chk("R10 ch1 vs model", reg_rdata[1], m_reg[1]);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule